// File: doc/BRIEF.md
# Mode-Aware Two-Half Issue Queue Steering

This block accepts one dispatched fixed-point or load/store operation per cycle and places it into one of two queue halves. Each half feeds its own fixed-point pipe and its own load/store pipe, and each half reads its own copy of the register file. The three-value mode input decides how an operation is placed.

In the single-thread and two-thread modes, both register copies hold the same data. An operation may go to either half, and the block picks the less loaded one. In the four-thread mode, the thread number fixes the half: threads 0 and 1 use half 0, and threads 2 and 3 use half 1. The `disp_half` output tells dispatch which register copy the operation will read.

Each half issues the oldest ready fixed-point operation and the oldest ready load/store operation every cycle. A tag scoreboard tracks when each result becomes visible to consumers. A result reaches consumers in the producer's own half after the producer's latency. It reaches consumers in the other half one cycle later.

Top module: `split_iq_steer`

## Requirements
- R1: While reset is held, and in the first cycle after it, both queue halves are empty, no grant is raised and `disp_stall` is low.
- R2: Free-steering modes are single-thread (`mode`=0) and two-thread (`mode`=1). In these modes an accepted operation goes to the half with fewer occupied entries, and ties go to half 0. `disp_half` reports the chosen half in the dispatch cycle.
- R3: In the free-steering modes a half holds at most DEPTH entries. Dispatch stalls only when both halves are full. A stalled operation is not accepted and leaves the occupancy unchanged.
- R4: In four-thread mode (`mode`=2 or 3), an operation from thread 0 or 1 goes to half 0 and one from thread 2 or 3 goes to half 1, whatever the occupancy. Dispatch stalls when that half is full, even if the other half has room.
- R5: Per half and per cycle, at most one fixed-point and one load/store grant is raised. When several entries are ready, the one dispatched earliest wins.
- R6: A fixed-point producer granted in cycle t lets a dependent operation in the same half be granted in cycle t+1.
- R7: A dependent operation in the other half from its fixed-point producer is granted no earlier than cycle t+2.
- R8: A load/store producer granted in cycle t wakes same-half consumers in cycle t+2 and other-half consumers in cycle t+3.
- R9: An operation is granted at the earliest in the cycle after its dispatch. A source whose valid flag is 0 never delays the operation, even when its tag names a pending result.
- R10: `disp_cls`=0 marks a fixed-point operation and `disp_cls`=1 a load/store operation. A grant appears on `fx_gnt[h]`/`fxh_tag` or `ls_gnt[h]`/`lsh_tag` for half h, with the tag set to the operation's destination tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 single-thread, 1 two-thread, 2 or 3 four-thread |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_tid | input | 2 | Thread number of the operation |
| disp_cls | input | 1 | 0 fixed-point, 1 load/store |
| disp_dst | input | TAG_W | Destination tag |
| disp_src_a | input | TAG_W | First source tag |
| disp_src_a_vld | input | 1 | First source is used |
| disp_src_b | input | TAG_W | Second source tag |
| disp_src_b_vld | input | 1 | Second source is used |
| disp_stall | output | 1 | Request not accepted this cycle |
| disp_half | output | 1 | Half (and register copy) chosen for the request |
| fx_gnt | output | 2 | Fixed-point grant per half |
| fx0_tag | output | TAG_W | Destination tag granted to fixed-point pipe 0 |
| fx1_tag | output | TAG_W | Destination tag granted to fixed-point pipe 1 |
| ls_gnt | output | 2 | Load/store grant per half |
| ls0_tag | output | TAG_W | Destination tag granted to load/store pipe 0 |
| ls1_tag | output | TAG_W | Destination tag granted to load/store pipe 1 |

## Verification
The bench builds the block with its defaults: DEPTH=24, TAG_W=6, LAT_FX=1, LAT_LS=2 and XPEN=1. With a depth of 24, both the single-half stall in four-thread mode and the double-full stall in free mode are reached within about fifty dispatches. Queue-filling operations wait on their own destination tag, so they never issue and the queue stays full. With these latencies, every same-half and cross-half wakeup distance (one, two or three cycles) occurs as a separate vector in the table.

// File: rtl/split_iq_steer.sv
module split_iq_steer #(
  parameter int DEPTH  = 24,
  parameter int TAG_W  = 6,
  parameter int LAT_FX = 1,
  parameter int LAT_LS = 2,
  parameter int XPEN   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             disp_valid,
  input  logic [1:0]       disp_tid,
  input  logic             disp_cls,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic [TAG_W-1:0] disp_src_a,
  input  logic             disp_src_a_vld,
  input  logic [TAG_W-1:0] disp_src_b,
  input  logic             disp_src_b_vld,
  output logic             disp_stall,
  output logic             disp_half,
  output logic [1:0]       fx_gnt,
  output logic [TAG_W-1:0] fx0_tag,
  output logic [TAG_W-1:0] fx1_tag,
  output logic [1:0]       ls_gnt,
  output logic [TAG_W-1:0] ls0_tag,
  output logic [TAG_W-1:0] ls1_tag
);
  localparam int NTAG    = 1 << TAG_W;
  localparam int OCC_W   = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int AGE_MAX = ((LAT_LS > LAT_FX) ? LAT_LS : LAT_FX) + XPEN;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  typedef struct packed {
    logic             cls;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] sa;
    logic             sav;
    logic [TAG_W-1:0] sb;
    logic             sbv;
  } ent_t;

  ent_t             q   [2][DEPTH];
  ent_t             nq  [2][DEPTH];
  logic [DEPTH-1:0] qv  [2];
  logic [DEPTH-1:0] nqv [2];
  logic [OCC_W-1:0] occ [2];
  logic [OCC_W-1:0] nocc[2];

  logic [NTAG-1:0]  t_busy, t_iss, t_ld, t_half;
  logic [AGE_W-1:0] t_age [NTAG];
  logic [NTAG-1:0]  trdy  [2];

  logic [DEPTH-1:0] erdy  [2];
  logic [1:0]       fx_hit, ls_hit;
  logic [IDX_W-1:0] fx_idx [2];
  logic [IDX_W-1:0] ls_idx [2];
  logic [TAG_W-1:0] fx_tag [2];
  logic [TAG_W-1:0] ls_tag [2];
  logic [NTAG-1:0]  g_hit, g_ld, g_half;

  logic free_mode, smt4, pick, accept;
  logic [1:0] full, push;
  logic unused_tid0;
  ent_t new_ent;

  assign unused_tid0 = disp_tid[0];
  assign free_mode   = (mode == 2'd0) || (mode == 2'd1);
  assign smt4        = !free_mode;
  assign full[0]     = occ[0] == FULL;
  assign full[1]     = occ[1] == FULL;

  always_comb begin
    if (smt4)         pick = disp_tid[1];
    else if (full[0]) pick = 1'b1;
    else if (full[1]) pick = 1'b0;
    else              pick = occ[1] < occ[0];
  end

  assign disp_stall = disp_valid && (smt4 ? full[pick] : (full[0] && full[1]));
  assign disp_half  = pick;
  assign accept     = disp_valid && !disp_stall;
  assign push[0]    = accept && !pick;
  assign push[1]    = accept && pick;
  assign new_ent    = '{cls: disp_cls, dst: disp_dst, sa: disp_src_a, sav: disp_src_a_vld,
                        sb: disp_src_b, sbv: disp_src_b_vld};

  // Result visibility per consuming half
  always_comb begin
    for (int h = 0; h < 2; h++) begin
      for (int t = 0; t < NTAG; t++) begin
        int need;
        need = (t_ld[t] ? LAT_LS : LAT_FX) + ((t_half[t] != h[0]) ? XPEN : 0);
        trdy[h][t] = !t_busy[t] || (t_iss[t] && (int'(t_age[t]) >= need));
      end
    end
  end

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < DEPTH; i++) begin
        erdy[h][i] = qv[h][i]
                   && (!q[h][i].sav || trdy[h][q[h][i].sa])
                   && (!q[h][i].sbv || trdy[h][q[h][i].sb]);
      end
    end
  end

  // Oldest ready per class: lowest slot index is oldest
  always_comb begin
    for (int h = 0; h < 2; h++) begin
      fx_hit[h] = 1'b0;
      ls_hit[h] = 1'b0;
      fx_idx[h] = '0;
      ls_idx[h] = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (erdy[h][i] && !q[h][i].cls) begin
          fx_hit[h] = 1'b1;
          fx_idx[h] = IDX_W'(i);
        end
        if (erdy[h][i] && q[h][i].cls) begin
          ls_hit[h] = 1'b1;
          ls_idx[h] = IDX_W'(i);
        end
      end
      fx_tag[h] = q[h][fx_idx[h]].dst;
      ls_tag[h] = q[h][ls_idx[h]].dst;
    end
  end

  assign fx_gnt  = fx_hit;
  assign ls_gnt  = ls_hit;
  assign fx0_tag = fx_tag[0];
  assign fx1_tag = fx_tag[1];
  assign ls0_tag = ls_tag[0];
  assign ls1_tag = ls_tag[1];

  // Compaction keeps dispatch order; new entry appended at the tail
  always_comb begin
    for (int h = 0; h < 2; h++) begin
      int k;
      k = 0;
      nqv[h] = '0;
      for (int i = 0; i < DEPTH; i++) nq[h][i] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (qv[h][i] && !(fx_hit[h] && fx_idx[h] == IDX_W'(i))
                     && !(ls_hit[h] && ls_idx[h] == IDX_W'(i))) begin
          nq[h][k]  = q[h][i];
          nqv[h][k] = 1'b1;
          k++;
        end
      end
      if (push[h] && k < DEPTH) begin
        nq[h][k]  = new_ent;
        nqv[h][k] = 1'b1;
        k++;
      end
      nocc[h] = OCC_W'(k);
    end
  end

  always_comb begin
    g_hit  = '0;
    g_ld   = '0;
    g_half = '0;
    for (int h = 0; h < 2; h++) begin
      if (fx_hit[h]) begin
        g_hit[fx_tag[h]]  = 1'b1;
        g_ld[fx_tag[h]]   = 1'b0;
        g_half[fx_tag[h]] = h[0];
      end
      if (ls_hit[h]) begin
        g_hit[ls_tag[h]]  = 1'b1;
        g_ld[ls_tag[h]]   = 1'b1;
        g_half[ls_tag[h]] = h[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        qv[h]  <= '0;
        occ[h] <= '0;
        for (int i = 0; i < DEPTH; i++) q[h][i] <= '0;
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        qv[h]  <= nqv[h];
        occ[h] <= nocc[h];
        for (int i = 0; i < DEPTH; i++) q[h][i] <= nq[h][i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_busy <= '0;
      t_iss  <= '0;
      t_ld   <= '0;
      t_half <= '0;
      for (int t = 0; t < NTAG; t++) t_age[t] <= '0;
    end else begin
      for (int t = 0; t < NTAG; t++) begin
        if (accept && disp_dst == TAG_W'(t)) begin
          t_busy[t] <= 1'b1;
          t_iss[t]  <= 1'b0;
          t_age[t]  <= '0;
        end else if (g_hit[t]) begin
          t_iss[t]  <= 1'b1;
          t_ld[t]   <= g_ld[t];
          t_half[t] <= g_half[t];
          t_age[t]  <= AGE_W'(1);
        end else if (t_iss[t] && t_age[t] < AGE_W'(AGE_MAX)) begin
          t_age[t]  <= t_age[t] + 1'b1;
        end
      end
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[0] <= FULL) && (occ[1] <= FULL));

  p_free_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (free_mode && disp_valid && disp_stall) |-> (full[0] && full[1]));

  p_held_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_stall && fx_gnt == 2'b00 && ls_gnt == 2'b00)
      |=> (occ[0] == $past(occ[0])) && (occ[1] == $past(occ[1])));

  p_smt4_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smt4 && disp_valid && disp_stall) |-> (occ[disp_tid[1]] == FULL));

  p_grant_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((fx_gnt[0] || ls_gnt[0]) |-> occ[0] != '0) and
    ((fx_gnt[1] || ls_gnt[1]) |-> occ[1] != '0));

  p_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push[0] && fx_gnt[0] == 1'b0 && ls_gnt[0] == 1'b0) |=> occ[0] == $past(occ[0]) + 1'b1);
endmodule

// File: tb/split_iq_steer_test.sv
module split_iq_steer_test;
  localparam int D  = 24;
  localparam int TW = 6;
  localparam int NV = 11;
  // {mode[1:0], producer tid[1:0], producer cls, consumer tid[1:0], consumer cls}
  localparam logic [7:0] VEC [NV] = '{
    {2'd2, 2'd0, 1'b0, 2'd1, 1'b0},
    {2'd2, 2'd0, 1'b0, 2'd2, 1'b0},
    {2'd2, 2'd3, 1'b0, 2'd2, 1'b0},
    {2'd2, 2'd1, 1'b0, 2'd3, 1'b0},
    {2'd2, 2'd0, 1'b1, 2'd0, 1'b0},
    {2'd2, 2'd0, 1'b1, 2'd2, 1'b0},
    {2'd2, 2'd2, 1'b1, 2'd3, 1'b1},
    {2'd2, 2'd0, 1'b0, 2'd0, 1'b1},
    {2'd0, 2'd0, 1'b0, 2'd0, 1'b0},
    {2'd0, 2'd0, 1'b1, 2'd0, 1'b0},
    {2'd1, 2'd1, 1'b1, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [1:0]    mode;
  logic          disp_valid;
  logic [1:0]    disp_tid;
  logic          disp_cls;
  logic [TW-1:0] disp_dst, disp_src_a, disp_src_b;
  logic          disp_src_a_vld, disp_src_b_vld;
  logic          disp_stall, disp_half;
  logic [1:0]    fx_gnt, ls_gnt;
  logic [TW-1:0] fx0_tag, fx1_tag, ls0_tag, ls1_tag;

  split_iq_steer uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_cls(disp_cls),
    .disp_dst(disp_dst), .disp_src_a(disp_src_a), .disp_src_a_vld(disp_src_a_vld),
    .disp_src_b(disp_src_b), .disp_src_b_vld(disp_src_b_vld),
    .disp_stall(disp_stall), .disp_half(disp_half),
    .fx_gnt(fx_gnt), .fx0_tag(fx0_tag), .fx1_tag(fx1_tag),
    .ls_gnt(ls_gnt), .ls0_tag(ls0_tag), .ls1_tag(ls1_tag)
  );

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input bit v, input logic [1:0] tid, input bit cls,
                     input logic [TW-1:0] dst, input logic [TW-1:0] sa, input bit sav);
    disp_valid = v; disp_tid = tid; disp_cls = cls; disp_dst = dst;
    disp_src_a = sa; disp_src_a_vld = sav; disp_src_b = '0; disp_src_b_vld = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0;
    mode  = m;
    put(0, 0, 0, 0, 0, 0);
    repeat (2) tick();
    rst_n = 1'b1;
  endtask

  function automatic bit seen(input int h, input bit cls, input logic [TW-1:0] tag);
    if (cls) return ls_gnt[h] && ((h == 0 ? ls0_tag : ls1_tag) == tag);
    return fx_gnt[h] && ((h == 0 ? fx0_tag : fx1_tag) == tag);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int nh1;
    do_reset(2'd0);
    rst_n = 1'b0;
    #1;
    // R1 during reset and right after
    chk(fx_gnt == 0 && ls_gnt == 0, "R1 grants in reset", {fx_gnt, ls_gnt}, 0);
    chk(disp_stall == 0, "R1 stall in reset", disp_stall, 0);
    tick();
    rst_n = 1'b1;
    tick();
    #1;
    chk(fx_gnt == 0 && ls_gnt == 0 && disp_stall == 0, "R1 after reset", {fx_gnt, ls_gnt, disp_stall}, 0);

    // Vector table: wakeup distances R6 R7 R8, placement R2 R4, routing R10
    for (int r = 0; r < NV; r++) begin
      logic [1:0] m, pt, ct;
      logic pc, cc;
      int ph, chf, expc, first;
      {m, pt, pc, ct, cc} = VEC[r];
      ph   = (m >= 2) ? int'(pt[1]) : 0;
      chf  = (m >= 2) ? int'(ct[1]) : 1;
      expc = 1 + (pc ? 2 : 1) + ((ph != chf) ? 1 : 0);
      do_reset(m);
      put(1, pt, pc, 6'd5, 6'd0, 0);
      #1;
      chk(disp_half == ph[0], (m >= 2) ? "R4 producer half" : "R2 producer half", disp_half, ph);
      tick();
      put(1, ct, cc, 6'd6, 6'd5, 1);
      #1;
      chk(disp_half == chf[0], (m >= 2) ? "R4 consumer half" : "R2 consumer half", disp_half, chf);
      chk(seen(ph, pc, 6'd5), "R10 producer grant port", 0, 1);
      tick();
      put(0, 0, 0, 0, 0, 0);
      first = -1;
      for (int c = 2; c < 8; c++) begin
        #1;
        if (first < 0 && seen(chf, cc, 6'd6)) first = c;
        tick();
      end
      if (pc)            chk(first == expc, "R8 load wakeup", first, expc);
      else if (ph == chf) chk(first == expc, "R6 same-half wakeup", first, expc);
      else               chk(first == expc, "R7 cross-half wakeup", first, expc);
    end

    // R2: alternating placement of never-ready entries
    do_reset(2'd0);
    for (int i = 0; i < 4; i++) begin
      put(1, 0, 0, 6'd63, 6'd63, 1);
      #1;
      chk(disp_half == i[0], "R2 balance", disp_half, i % 2);
      tick();
    end

    // R3: fill both halves in two-thread mode
    do_reset(2'd1);
    nh1 = 0;
    for (int i = 0; i < 2 * D; i++) begin
      put(1, 2'(i), 0, 6'd63, 6'd63, 1);
      #1;
      if (disp_stall) chk(0, "R3 early stall", i, 2 * D);
      nh1 += disp_half;
      tick();
    end
    chk(nh1 == D, "R3 both halves used", nh1, D);
    put(1, 0, 0, 6'd7, 6'd0, 0);
    #1;
    chk(disp_stall == 1, "R3 stall when both full", disp_stall, 1);
    tick();
    put(0, 0, 0, 0, 0, 0);
    tick();
    #1;
    chk(fx_gnt == 0, "R3 stalled op not accepted", fx_gnt, 0);

    // R4: four-thread fixed placement and single-half stall
    do_reset(2'd2);
    for (int i = 0; i < D; i++) begin
      put(1, 2'd1, 0, 6'd63, 6'd63, 1);
      #1;
      if (disp_half != 0 || disp_stall) chk(0, "R4 thread1 to half0", disp_half, 0);
      tick();
    end
    put(1, 2'd0, 0, 6'd8, 6'd0, 0);
    #1;
    chk(disp_stall == 1, "R4 stall with half0 full", disp_stall, 1);
    tick();
    put(1, 2'd2, 0, 6'd9, 6'd0, 0);
    #1;
    chk(disp_stall == 0 && disp_half == 1, "R4 thread2 to half1", {disp_stall, disp_half}, 1);
    tick();
    put(0, 0, 0, 0, 0, 0);
    #1;
    chk(seen(1, 0, 6'd9) && fx_gnt[0] == 0, "R4 thread2 issues on pipe1", fx_gnt, 2);
    mode = 2'd1;
    put(1, 2'd0, 0, 6'd63, 6'd63, 1);
    #1;
    chk(disp_stall == 0 && disp_half == 1, "R2 free mode avoids full half", {disp_stall, disp_half}, 1);
    tick();

    // R5: oldest ready first, one FX plus one LS per half
    do_reset(2'd2);
    put(1, 0, 1, 6'd10, 6'd0, 0);
    tick();
    put(1, 0, 0, 6'd11, 6'd10, 1);
    tick();
    put(1, 0, 0, 6'd12, 6'd10, 1);
    tick();
    put(1, 0, 1, 6'd13, 6'd10, 1);
    #1;
    chk(seen(0, 0, 6'd11), "R5 oldest FX first", fx0_tag, 11);
    tick();
    put(0, 0, 0, 0, 0, 0);
    #1;
    chk(seen(0, 0, 6'd12), "R5 younger FX next", fx0_tag, 12);
    chk(seen(0, 1, 6'd13), "R5 LS granted alongside", ls0_tag, 13);

    // R9: unused source flag ignores a pending tag
    do_reset(2'd2);
    put(1, 0, 0, 6'd63, 6'd63, 1);
    #1;
    chk(fx_gnt == 0, "R9 no grant in dispatch cycle", fx_gnt, 0);
    tick();
    put(1, 0, 0, 6'd7, 6'd63, 0);
    tick();
    put(0, 0, 0, 0, 0, 0);
    #1;
    chk(seen(0, 0, 6'd7), "R9 invalid source ignored", fx0_tag, 7);
    tick();
    #1;
    chk(fx_gnt == 0, "R9 blocker still waiting", fx_gnt, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule